// File: doc/BRIEF.md
# Capacitor Bank Charge/Discharge Pulse Sequencer

This block is the timing core of a spark-erosion pulse generator. It alternates a capacitor bank between a charging phase and a discharging phase. It advances only on events: a phase ends when the condition it waits for has been seen, not on a free-running clock. Two comparator flags feed it:

- **bank-full:** the bank has reached its upper threshold.
- **bank-empty:** the bank has fallen below its lower threshold.

Both flags arrive asynchronously. Each passes through a synchronizer and a glitch filter that rejects arc noise. A run enable gates the whole sequence.

Two configuration words set the pulse:

- the maximum discharge on-time, in clock cycles;
- the minimum start-to-start spacing between discharge pulses, in clock cycles.

Each word is clamped to a parameter range. The integrator derives that range from the clock rate, for example 50 to 200 us of on-time and 200 us to 2 ms of spacing.

The two outputs are charge-enable and discharge-enable. They are never high together. A dead time of at least one cycle, with both outputs low, separates each handover. A bank-full edge is held until the spacing has elapsed, so an early charge never loses a pulse. Edges seen while the bank is discharging are dropped, so a trigger cannot re-arm a pulse in flight.

Top module: `spark_pulse_seq`

## Requirements
- R1: While reset is held, chg_en is 1 and dis_en is 0 (the sequencer starts in the charge phase).
- R2: In the charge phase, a rising edge of the conditioned bank_full flag ends charging once the spacing allows. dis_en then rises after DEAD_CYC cycles with both enables low.
- R3: A bank_full rising edge seen outside the charge phase is dropped. After the pulse ends, no discharge starts until a new edge arrives during charging.
- R4: chg_en and dis_en are never 1 in the same cycle.
- R5: Every switch between the enables has at least DEAD_CYC cycles with both low. No enable rises in the cycle right after the other was high.
- R6: If the conditioned bank_empty stays 0, dis_en stays high for exactly clamp(pw_cfg, PW_MIN, PW_MAX) cycles. A value below PW_MIN gives PW_MIN; a value above PW_MAX gives PW_MAX.
- R7: A conditioned bank_empty level of 1 during discharge ends the pulse before the width limit.
- R8: Two consecutive rising edges of dis_en are at least clamp(ival_cfg, GAP_MIN, GAP_MAX) cycles apart. If the trigger was already pending, the spacing is exactly that value.
- R9: After reset or after run_en rises, the spacing gate is open, so the first pulse waits only for the trigger path. The width timer is held at zero outside discharge.
- R10: Each flag passes a SYNC_STAGES-flop synchronizer and a glitch filter. A level change shorter than FILT_LEN cycles is ignored; one that lasts FILT_LEN cycles is taken.
- R11: After a clock edge that sees run_en at 0, both enables are 0 and the sequencer idles. After the first edge that sees run_en at 1 again, chg_en is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low forces idle with both enables off |
| bank_full_raw | input | 1 | Asynchronous flag: bank reached its upper threshold |
| bank_empty_raw | input | 1 | Asynchronous flag: bank dropped below its lower threshold |
| pw_cfg | input | CFG_W | Maximum discharge on-time in cycles (clamped) |
| ival_cfg | input | CFG_W | Minimum pulse start-to-start spacing in cycles (clamped) |
| chg_en | output | 1 | Charge-phase enable |
| dis_en | output | 1 | Discharge-phase enable |

## Verification
A phase register stuck in the wrong state would show up right away at the ports:

- an enable left high, or both enables together;
- a pulse that starts without a fresh bank_full edge after charging began;
- a pulse whose length differs from the clamped width.

A spacing counter that is wrong moves the start of the next pulse away from the exact expected spacing, and the bench measures that from one pulse start to the next. A glitch filter that miscounts either fires on a pulse of FILT_LEN-1 cycles or misses one of FILT_LEN cycles. That shows up about SYNC_STAGES+FILT_LEN+3 cycles after the stimulus.

// File: rtl/spark_seq_pkg.sv
package spark_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_CHARGE = 3'd1,
      PH_GAP_CD = 3'd2,
      PH_FIRE   = 3'd3,
      PH_GAP_DC = 3'd4
   } phase_e;

endpackage

// File: rtl/spark_flag_cond.sv
module spark_flag_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic level_out
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spark_flag_cond: SYNC_STAGES must be at least 2");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("spark_flag_cond: FILT_LEN must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
   end

   assign sync_out = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN <= 1) begin : g_no_filter
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level_out <= 1'b0;
            else        level_out <= sync_out;
         end
      end else begin : g_filter
         localparam int FCW = $clog2(FILT_LEN + 1);
         localparam logic [FCW-1:0] LAST = FCW'(FILT_LEN - 1);
         logic [FCW-1:0] run_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt   <= '0;
               level_out <= 1'b0;
            end else if (sync_out == level_out) begin
               run_cnt   <= '0;
            end else if (run_cnt == LAST) begin
               run_cnt   <= '0;
               level_out <= sync_out;
            end else begin
               run_cnt   <= run_cnt + 1'b1;
            end
         end
      end
   endgenerate

   // R10: the filtered level only moves to a value the synchronizer already held
   p_filter_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (level_out != $past(level_out)) |-> (level_out == $past(sync_out)));

endmodule

// File: rtl/spark_cfg_clamp.sv
module spark_cfg_clamp #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 8,
   parameter int LO    = 1,
   parameter int HI    = 255
) (
   input  logic [IN_W-1:0]  cfg_in,
   output logic [OUT_W-1:0] cfg_out
);

   generate
      if (HI < LO) begin : g_bad_range
         $error("spark_cfg_clamp: HI below LO");
      end
      if ((1 << OUT_W) <= HI) begin : g_bad_out
         $error("spark_cfg_clamp: OUT_W too narrow for HI");
      end
      if (IN_W < OUT_W) begin : g_bad_in
         $error("spark_cfg_clamp: IN_W narrower than OUT_W");
      end
   endgenerate

   localparam logic [IN_W-1:0]  LO_IN  = IN_W'(LO);
   localparam logic [IN_W-1:0]  HI_IN  = IN_W'(HI);
   localparam logic [OUT_W-1:0] LO_OUT = OUT_W'(LO);
   localparam logic [OUT_W-1:0] HI_OUT = OUT_W'(HI);

   always_comb begin
      if (cfg_in < LO_IN)      cfg_out = LO_OUT;
      else if (cfg_in > HI_IN) cfg_out = HI_OUT;
      else                     cfg_out = cfg_in[OUT_W-1:0];
   end

endmodule

// File: rtl/spark_tick_count.sv
module spark_tick_count #(
   parameter int W        = 8,
   parameter int MAX      = 255,
   parameter bit RST_FULL = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_full,
   input  logic         ld_one,
   input  logic         hold_zero,
   output logic [W-1:0] cnt
);

   generate
      if ((1 << W) <= MAX) begin : g_bad_width
         $error("spark_tick_count: W too narrow for MAX");
      end
   endgenerate

   localparam logic [W-1:0] FULL    = W'(MAX);
   localparam logic [W-1:0] RST_VAL = RST_FULL ? FULL : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= RST_VAL;
      else if (ld_full)       cnt <= FULL;
      else if (ld_one)        cnt <= W'(1);
      else if (hold_zero)     cnt <= '0;
      else if (cnt != FULL)   cnt <= cnt + 1'b1;
   end

   // R8: once saturated, the count stays put until a load or clear
   p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == FULL && !ld_one && !hold_zero) |=> (cnt == FULL));

endmodule

// File: rtl/spark_phase_fsm.sv
module spark_phase_fsm
   import spark_seq_pkg::*;
#(
   parameter int DEAD_CYC = 1,
   parameter int PW_CW    = 6,
   parameter int IV_CW    = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             full_lvl,
   input  logic             empty_lvl,
   input  logic [PW_CW-1:0] pw_eff,
   input  logic [IV_CW-1:0] iv_eff,
   input  logic [PW_CW-1:0] w_cnt,
   input  logic [IV_CW-1:0] i_cnt,
   output logic             fire_entry,
   output logic             fire_next,
   output logic             idle_next,
   output logic             chg_q,
   output logic             dis_q
);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("spark_phase_fsm: DEAD_CYC must be at least 1");
      end
   endgenerate

   localparam int DC_W = $clog2(DEAD_CYC + 1);
   localparam logic [DC_W-1:0]  DC_LAST = DC_W'(DEAD_CYC - 1);
   localparam logic [IV_CW:0]   DEAD_EXT = (IV_CW+1)'(DEAD_CYC);

   phase_e          state_q, state_d;
   logic [DC_W-1:0] dcnt_q;
   logic            full_d_q;
   logic            pend_q, pend_d;
   logic            full_rise;
   logic            pend_now;
   logic            gap_open;
   logic            dead_done;
   logic            width_done;

   assign full_rise  = full_lvl & ~full_d_q;
   assign pend_now   = pend_q | full_rise;
   assign gap_open   = ({1'b0, i_cnt} + DEAD_EXT) >= {1'b0, iv_eff};
   assign dead_done  = (dcnt_q == DC_LAST);
   assign width_done = (w_cnt >= pw_eff);

   always_comb begin
      state_d = state_q;
      if (!run_en) begin
         state_d = PH_IDLE;
      end else begin
         unique case (state_q)
            PH_IDLE:   state_d = PH_CHARGE;
            PH_CHARGE: if (pend_now && gap_open) state_d = PH_GAP_CD;
            PH_GAP_CD: if (dead_done) state_d = PH_FIRE;
            PH_FIRE:   if (empty_lvl || width_done) state_d = PH_GAP_DC;
            PH_GAP_DC: if (dead_done) state_d = PH_CHARGE;
            default:   state_d = PH_IDLE;
         endcase
      end
   end

   always_comb begin
      if (state_q == PH_CHARGE && state_d == PH_CHARGE) pend_d = pend_now;
      else                                             pend_d = 1'b0;
   end

   assign fire_next  = (state_d == PH_FIRE);
   assign fire_entry = fire_next && (state_q != PH_FIRE);
   assign idle_next  = (state_d == PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PH_CHARGE;
         dcnt_q   <= '0;
         full_d_q <= 1'b0;
         pend_q   <= 1'b0;
         chg_q    <= 1'b1;
         dis_q    <= 1'b0;
      end else begin
         state_q  <= state_d;
         full_d_q <= full_lvl;
         pend_q   <= pend_d;
         chg_q    <= (state_d == PH_CHARGE);
         dis_q    <= (state_d == PH_FIRE);
         if ((state_q == PH_GAP_CD || state_q == PH_GAP_DC) && state_d == state_q)
            dcnt_q <= dcnt_q + 1'b1;
         else
            dcnt_q <= '0;
      end
   end

   // R3: a held trigger never survives outside the charge phase
   p_no_pend_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PH_CHARGE) |=> !pend_q);

   // R6: the width counter never runs past the clamped width during a pulse
   p_width_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PH_FIRE) |-> (w_cnt <= pw_eff));

   // R9: the width timer stays cleared whenever no pulse is active
   p_width_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != PH_FIRE) |-> (w_cnt == '0));

endmodule

// File: rtl/spark_pulse_seq.sv
module spark_pulse_seq #(
   parameter int CFG_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter int DEAD_CYC    = 1,
   parameter int PW_MIN      = 4,
   parameter int PW_MAX      = 40,
   parameter int GAP_MIN     = 64,
   parameter int GAP_MAX     = 400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             bank_full_raw,
   input  logic             bank_empty_raw,
   input  logic [CFG_W-1:0] pw_cfg,
   input  logic [CFG_W-1:0] ival_cfg,
   output logic             chg_en,
   output logic             dis_en
);

   localparam int PW_CW = $clog2(PW_MAX + 1);
   localparam int IV_CW = $clog2(GAP_MAX + 1);

   generate
      if (PW_MIN < 1) begin : g_bad_pwmin
         $error("spark_pulse_seq: PW_MIN must be at least 1");
      end
      if (GAP_MIN <= PW_MAX + 2 * DEAD_CYC) begin : g_bad_gap
         $error("spark_pulse_seq: GAP_MIN must exceed PW_MAX plus both dead times");
      end
      if (CFG_W < IV_CW) begin : g_bad_cfg
         $error("spark_pulse_seq: CFG_W too narrow for GAP_MAX");
      end
   endgenerate

   logic             full_lvl, empty_lvl;
   logic [PW_CW-1:0] pw_eff, w_cnt;
   logic [IV_CW-1:0] iv_eff, i_cnt;
   logic             fire_entry, fire_next, idle_next;

   spark_flag_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_full_cond (
      .clk(clk), .rst_n(rst_n), .raw_in(bank_full_raw), .level_out(full_lvl));

   spark_flag_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_empty_cond (
      .clk(clk), .rst_n(rst_n), .raw_in(bank_empty_raw), .level_out(empty_lvl));

   spark_cfg_clamp #(.IN_W(CFG_W), .OUT_W(PW_CW), .LO(PW_MIN), .HI(PW_MAX)) u_pw_clamp (
      .cfg_in(pw_cfg), .cfg_out(pw_eff));

   spark_cfg_clamp #(.IN_W(CFG_W), .OUT_W(IV_CW), .LO(GAP_MIN), .HI(GAP_MAX)) u_iv_clamp (
      .cfg_in(ival_cfg), .cfg_out(iv_eff));

   spark_tick_count #(.W(PW_CW), .MAX(PW_MAX), .RST_FULL(1'b0)) u_width_timer (
      .clk(clk), .rst_n(rst_n), .ld_full(1'b0), .ld_one(fire_entry),
      .hold_zero(!fire_next), .cnt(w_cnt));

   spark_tick_count #(.W(IV_CW), .MAX(GAP_MAX), .RST_FULL(1'b1)) u_gap_timer (
      .clk(clk), .rst_n(rst_n), .ld_full(idle_next), .ld_one(fire_entry),
      .hold_zero(1'b0), .cnt(i_cnt));

   spark_phase_fsm #(.DEAD_CYC(DEAD_CYC), .PW_CW(PW_CW), .IV_CW(IV_CW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .full_lvl(full_lvl), .empty_lvl(empty_lvl),
      .pw_eff(pw_eff), .iv_eff(iv_eff), .w_cnt(w_cnt), .i_cnt(i_cnt),
      .fire_entry(fire_entry), .fire_next(fire_next), .idle_next(idle_next),
      .chg_q(chg_en), .dis_q(dis_en));

   // R4: the two enables are mutually exclusive
   p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(chg_en && dis_en));

   // R5: discharge never starts straight out of a charging cycle
   p_dead_cd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis_en) |-> !$past(chg_en));

   // R5: charging never resumes straight out of a discharging cycle
   p_dead_dc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_en) |-> !$past(dis_en));

   // R11: a low run enable drops both enables after the next edge
   p_run_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!chg_en && !dis_en));

endmodule

// File: tb/spark_pulse_seq_tb.sv
module spark_pulse_seq_tb_top;

   localparam int CFG_W    = 16;
   localparam int FILT     = 4;
   localparam int DEAD     = 1;
   localparam int PW_MIN   = 4;
   localparam int PW_MAX   = 40;
   localparam int GAP_MIN  = 64;
   localparam int GAP_MAX  = 400;

   logic             clk = 1'b0;
   logic             rst_n = 1'b1;
   logic             run_en = 1'b0;
   logic             full_raw = 1'b0;
   logic             empty_raw = 1'b0;
   logic [CFG_W-1:0] pw_cfg = 16'd20;
   logic [CFG_W-1:0] ival_cfg = 16'd100;
   logic             chg_en, dis_en;

   int n_chk = 0;
   int n_fail = 0;
   int ncyc = 0;
   int viol_excl = 0;
   int viol_dead = 0;
   logic chg_p = 1'b0, dis_p = 1'b0;

   always #2 clk = ~clk;

   spark_pulse_seq #(
      .CFG_W(CFG_W), .SYNC_STAGES(2), .FILT_LEN(FILT), .DEAD_CYC(DEAD),
      .PW_MIN(PW_MIN), .PW_MAX(PW_MAX), .GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .bank_full_raw(full_raw), .bank_empty_raw(empty_raw),
      .pw_cfg(pw_cfg), .ival_cfg(ival_cfg),
      .chg_en(chg_en), .dis_en(dis_en));

   always @(posedge clk) ncyc <= ncyc + 1;

   // overlap and dead-time monitor (R4, R5), sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (chg_en && dis_en) viol_excl++;
         if (dis_en && !dis_p && chg_p) viol_dead++;
         if (chg_en && !chg_p && dis_p) viol_dead++;
      end
      chg_p = chg_en;
      dis_p = dis_en;
   end

   function automatic int clampi(int v, int lo, int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_dis(logic val, int lim, output int t, output bit ok);
      ok = 1'b0;
      t  = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (dis_en == val) begin
            ok = 1'b1;
            t  = ncyc;
            return;
         end
      end
   endtask

   task automatic wait_chg(int lim, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (chg_en) begin
            ok = 1'b1;
            return;
         end
      end
   endtask

   task automatic full_pulse(int len);
      full_raw = 1'b1;
      step(len);
      full_raw = 1'b0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      finish_run();
   end

   initial begin
      int  t, tf, prev, t_hi, pw_x, iv_x;
      bit  ok, have_prev;
      void'($urandom(32'h5A17));

      // ---- reset state (R1) and run gating (R11)
      #1 rst_n = 1'b0;
      step(3);
      chk(chg_en == 1'b1 && dis_en == 1'b0, "R1", "reset chg/dis",
          {chg_en, dis_en}, 2);
      rst_n = 1'b1;
      step(1);
      chk(!chg_en && !dis_en, "R11", "run low after reset", {chg_en, dis_en}, 0);
      run_en = 1'b1;
      step(1);
      chk(chg_en && !dis_en, "R11", "charge after run rise", {chg_en, dis_en}, 2);

      // ---- random pulses (R2, R6, R7, R8, R9)
      have_prev = 1'b0;
      prev = 0;
      for (int it = 0; it < 30; it++) begin
         int pw_r, iv_r;
         pw_r = (it == 0) ? 0 : int'($urandom_range(0, 50));
         iv_r = (it == 1) ? 0 : int'($urandom_range(0, 460));
         pw_cfg   = CFG_W'(pw_r);
         ival_cfg = CFG_W'(iv_r);
         pw_x = clampi(pw_r, PW_MIN, PW_MAX);
         iv_x = clampi(iv_r, GAP_MIN, GAP_MAX);
         wait_chg(50, ok);
         chk(ok, "R5", "charge resumes after pulse", int'(ok), 1);
         t_hi = ncyc;
         full_pulse(FILT + 3);
         wait_dis(1'b1, GAP_MAX + 100, t, ok);
         chk(ok, "R2", "discharge after full edge", int'(ok), 1);
         if (have_prev)
            chk(t - prev == iv_x, "R8", "start-to-start spacing", t - prev, iv_x);
         else
            chk(t - t_hi <= FILT + 6, "R9", "first pulse latency", t - t_hi, FILT + 6);
         prev = t;
         have_prev = 1'b1;
         if (pw_x >= 20 && $urandom_range(0, 1) == 1) begin
            step(2);
            empty_raw = 1'b1;
            wait_dis(1'b0, PW_MAX + 10, tf, ok);
            empty_raw = 1'b0;
            chk(ok && (tf - t) >= 3 && (tf - t) <= FILT + 8 && (tf - t) < pw_x,
                "R7", "early end on empty flag", tf - t, FILT + 8);
         end else begin
            wait_dis(1'b0, PW_MAX + 10, tf, ok);
            chk(ok && (tf - t) == pw_x, "R6", "pulse width", tf - t, pw_x);
         end
      end

      // ---- glitch filter boundary (R10)
      pw_cfg   = CFG_W'(PW_MAX);
      ival_cfg = CFG_W'(GAP_MIN);
      wait_chg(50, ok);
      step(GAP_MIN + 20);
      full_pulse(1);
      wait_dis(1'b1, 40, t, ok);
      chk(!ok && chg_en, "R10", "one-cycle glitch fired", int'(ok), 0);
      full_pulse(FILT - 1);
      wait_dis(1'b1, 40, t, ok);
      chk(!ok && chg_en, "R10", "short pulse fired", int'(ok), 0);
      full_pulse(FILT);
      wait_dis(1'b1, 30, t, ok);
      chk(ok, "R10", "full-length pulse ignored", int'(ok), 1);

      // ---- trigger during discharge is dropped (R3), max width (R6)
      step(2);
      full_pulse(6);
      wait_dis(1'b0, PW_MAX + 10, tf, ok);
      chk(ok && (tf - t) == PW_MAX, "R6", "clamped max width", tf - t, PW_MAX);
      wait_dis(1'b1, GAP_MAX + 60, t, ok);
      chk(!ok && chg_en, "R3", "mid-pulse trigger re-armed", int'(ok), 0);

      // ---- run drop mid-pulse (R11) and open gate on restart (R9)
      full_pulse(6);
      wait_dis(1'b1, GAP_MAX + 60, t, ok);
      chk(ok, "R2", "discharge after fresh edge", int'(ok), 1);
      step(3);
      run_en = 1'b0;
      step(1);
      chk(!chg_en && !dis_en, "R11", "run drop mid-pulse", {chg_en, dis_en}, 0);
      step(10);
      chk(!chg_en && !dis_en, "R11", "idle holds while run low", {chg_en, dis_en}, 0);
      run_en = 1'b1;
      step(1);
      chk(chg_en && !dis_en, "R11", "charge after rerun", {chg_en, dis_en}, 2);
      t_hi = ncyc;
      full_pulse(FILT + 1);
      wait_dis(1'b1, 30, t, ok);
      chk(ok && (t - t_hi) <= FILT + 6, "R9", "restart pulse not delayed", t - t_hi, FILT + 6);
      wait_dis(1'b0, PW_MAX + 10, tf, ok);
      chk(ok && (tf - t) == PW_MAX, "R6", "width after restart", tf - t, PW_MAX);
      step(5);

      chk(viol_excl == 0, "R4", "overlap cycles", viol_excl, 0);
      chk(viol_dead == 0, "R5", "missing dead time", viol_dead, 0);
      finish_run();
   end

endmodule